// File: doc/BRIEF.md
# Daisy-chained configuration shift register

This block holds a serial configuration word that can be passed from chip to chip. Configuration bits enter one per clock at the serial input and move toward the high end of the word. The last bit is presented at the serial output, which feeds the serial input of the next chip in the chain. All chips share the clock. The parallel configuration word is available at the outputs at all times.

Each bit has two flip-flops. A rising-edge capture stage holds the bit, and its value is the parallel output. A falling-edge launch stage copies the capture stage and drives the next bit's input. The serial output therefore changes half a period before the receiving chip samples it. This gives half a clock period of hold and setup margin between chips, and the host still loads N bits with exactly N clocks.

A high level on the asynchronous reset forces both stages of every bit to a default value. The default is a parameter with one bit per stage: a `1` bit builds a set flop, and a `0` bit builds a clear flop.

Top module: `cfg_daisy_chain`

## Requirements
- R1: On each rising clock edge outside reset, `cfg_o[0]` takes the value of `ser_i`, and `cfg_o[i]` for i > 0 takes the value `cfg_o[i-1]` held before that edge. The word shifts toward the high index.
- R2: `ser_o` changes only on falling clock edges. After a falling edge it equals `cfg_o[N-1]` as captured at the preceding rising edge, and a rising edge leaves it unchanged.
- R3: N rising edges load N bits. The bit presented at rising edge k (k = 1..N) ends in `cfg_o[N-k]`. When two blocks are chained, the downstream block holds the first N bits of a 2N-bit stream and the upstream block holds the last N.
- R4: Asserting `rst_i` immediately sets `cfg_o` to `DEFAULT` and `ser_o` to `DEFAULT[N-1]`, without waiting for a clock edge.
- R5: While `rst_i` is high, rising and falling clock edges change nothing, whatever the value of `ser_i`.
- R6: After reset is released, the first rising edges shift the default contents onward. The downstream chip receives `DEFAULT[N-1]`, then `DEFAULT[N-2]`, and so on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shift clock; capture on rising edge, launch on falling edge |
| rst_i | input | 1 | Asynchronous active-high reset to the per-bit defaults |
| ser_i | input | 1 | Serial configuration data from the host or the previous chip |
| ser_o | output | 1 | Serial data to the next chip, launched on the falling edge |
| cfg_o | output | N | Parallel configuration word from the capture stages |

## Verification
Reset and shifting can fall in the same cycle. The bench raises reset between a falling and a rising edge, partway through a stream, while `ser_i` keeps toggling. It expects the defaults at once, and it expects them to stay through the following edges. The other overlap is at the boundary between chips: the upstream launch and the downstream capture happen in one clock period. The bench chains two instances and has a scoreboard predict both parallel words after every rising edge. Separate samples taken after falling edges confirm that the serial outputs moved on the falling edge and not on the rising one.

// File: rtl/cfg_chain_pkg.sv
package cfg_chain_pkg;

  // Both stages of one configuration bit.
  typedef struct packed {
    logic cap;     // rising-edge stage (parallel value)
    logic launch;  // falling-edge stage (drives next bit)
  } cfg_stage_t;

  // True when the launch stage has caught up with the capture stage.
  function automatic logic stage_aligned(input cfg_stage_t s);
    return s.cap == s.launch;
  endfunction

endpackage

// File: rtl/cfg_capture_ff.sv
module cfg_capture_ff #(
  parameter logic DEF_BIT = 1'b0
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic d_i,
  output logic q_o
);
  if (DEF_BIT) begin : g_set
    always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i) q_o <= 1'b1;
      else       q_o <= d_i;
    end
  end else begin : g_clr
    always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i) q_o <= 1'b0;
      else       q_o <= d_i;
    end
  end
endmodule

// File: rtl/cfg_launch_ff.sv
module cfg_launch_ff #(
  parameter logic DEF_BIT = 1'b0
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic d_i,
  output logic q_o
);
  if (DEF_BIT) begin : g_set
    always_ff @(negedge clk_i or posedge rst_i) begin
      if (rst_i) q_o <= 1'b1;
      else       q_o <= d_i;
    end
  end else begin : g_clr
    always_ff @(negedge clk_i or posedge rst_i) begin
      if (rst_i) q_o <= 1'b0;
      else       q_o <= d_i;
    end
  end
endmodule

// File: rtl/cfg_cell.sv
module cfg_cell
  import cfg_chain_pkg::*;
#(
  parameter logic DEF_BIT = 1'b0
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       din_i,
  output cfg_stage_t st_o
);
  logic cap_q;
  logic launch_q;
  logic primed_q;  // a rising edge out of reset has occurred

  cfg_capture_ff #(.DEF_BIT(DEF_BIT)) u_cap (
    .clk_i(clk_i), .rst_i(rst_i), .d_i(din_i), .q_o(cap_q)
  );

  cfg_launch_ff #(.DEF_BIT(DEF_BIT)) u_launch (
    .clk_i(clk_i), .rst_i(rst_i), .d_i(cap_q), .q_o(launch_q)
  );

  always_ff @(posedge clk_i or posedge rst_i) begin
    if (rst_i) primed_q <= 1'b0;
    else       primed_q <= 1'b1;
  end

  assign st_o = '{cap: cap_q, launch: launch_q};

  // R1
  cap_follows_din_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    primed_q |-> (cap_q == $past(din_i)));

  // R2
  launch_caught_up_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    stage_aligned(st_o));

  // R4 R5
  cell_default_chk: assert property (@(posedge clk_i)
    rst_i |-> (cap_q == DEF_BIT && launch_q == DEF_BIT));

endmodule

// File: rtl/cfg_daisy_chain.sv
module cfg_daisy_chain
  import cfg_chain_pkg::*;
#(
  parameter int unsigned     N       = 8,
  parameter logic [N-1:0]    DEFAULT = 8'hA6
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         ser_i,
  output logic         ser_o,
  output logic [N-1:0] cfg_o
);
  localparam int unsigned LAST = N - 1;

  logic [N-1:0] din_w;        // input to each bit's capture stage
  cfg_stage_t   stg_w [N];    // both stages of every bit
  logic         primed_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    if (i == 0) begin : g_head
      assign din_w[i] = ser_i;
    end else begin : g_link
      assign din_w[i] = stg_w[i-1].launch;
    end

    cfg_cell #(.DEF_BIT(DEFAULT[i])) u_cell (
      .clk_i (clk_i),
      .rst_i (rst_i),
      .din_i (din_w[i]),
      .st_o  (stg_w[i])
    );

    assign cfg_o[i] = stg_w[i].cap;
  end

  assign ser_o = stg_w[LAST].launch;

  always_ff @(posedge clk_i or posedge rst_i) begin
    if (rst_i) primed_q <= 1'b0;
    else       primed_q <= 1'b1;
  end

  // R1
  head_shift_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    primed_q |-> (cfg_o[0] == $past(ser_i)));

  if (N > 1) begin : g_body_chk
    // R1
    body_shift_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      primed_q |-> (cfg_o[LAST:1] == $past(cfg_o[LAST-1:0])));
  end

  // R2
  ser_out_tracks_last_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    ser_o == cfg_o[LAST]);

  // R4 R5
  word_default_chk: assert property (@(posedge clk_i)
    rst_i |-> (cfg_o == DEFAULT && ser_o == DEFAULT[LAST]));

endmodule

// File: tb/cfg_daisy_chain_test.sv
module cfg_daisy_chain_test;
  localparam int P = 10;
  localparam logic [7:0]  UP_DEF = 8'hA6;
  localparam logic [7:0]  DN_DEF = 8'h3C;
  localparam logic [15:0] DEFS   = {DN_DEF, UP_DEF};

  logic clk = 1'b0;
  logic rst = 1'b0;
  logic ser_in = 1'b0;
  logic up_so, dn_so;
  logic [7:0] up_cfg, dn_cfg;

  always #(P/2) clk = ~clk;

  cfg_daisy_chain #(.N(8), .DEFAULT(UP_DEF)) uut (
    .clk_i(clk), .rst_i(rst), .ser_i(ser_in), .ser_o(up_so), .cfg_o(up_cfg)
  );

  cfg_daisy_chain #(.N(8), .DEFAULT(DN_DEF)) uut_dn (
    .clk_i(clk), .rst_i(rst), .ser_i(up_so), .ser_o(dn_so), .cfg_o(dn_cfg)
  );

  typedef struct {
    logic [15:0] cfg;
    logic        up_so;
    logic        dn_so;
    string       req;
  } item_t;

  item_t sbq[$];
  item_t it;
  logic [15:0] chain;  // bench model: index 0..7 upstream, 8..15 downstream
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Driver: one call per clock period, drives at the falling edge.
  task automatic tick(input logic b, input string req);
    logic [15:0] old;
    item_t e;
    @(negedge clk);
    ser_in = b;
    old = chain;
    if (rst) chain = DEFS;
    else     chain = {chain[14:0], b};
    e.cfg   = chain;
    e.up_so = rst ? DEFS[7]  : old[7];
    e.dn_so = rst ? DEFS[15] : old[15];
    e.req   = req;
    sbq.push_back(e);
    #(P/4);
    // R2: launch stages now show what was captured at the last rising edge
    chk("R2 falling-edge launch", {14'b0, dn_so, up_so}, {14'b0, old[15], old[7]});
  endtask

  task automatic shift_word(input logic [15:0] w, input string req);
    for (int i = 15; i >= 0; i--) tick(w[i], req);
  endtask

  task automatic check_slices(input logic [15:0] w);
    @(posedge clk);
    #(P/8);
    chk("R3 upstream slice",   {8'b0, up_cfg}, {8'b0, w[7:0]});
    chk("R3 downstream slice", {8'b0, dn_cfg}, {8'b0, w[15:8]});
  endtask

  task automatic release_reset();
    @(posedge clk);
    #1 rst = 1'b0;
  endtask

  // Monitor: compares after every rising edge that has an expected item.
  initial begin
    forever begin
      @(posedge clk);
      #(P/4);
      if (sbq.size() > 0) begin
        it = sbq.pop_front();
        chk({it.req, " word"}, {dn_cfg, up_cfg}, it.cfg);
        chk({it.req, " serial held over rising edge (R2)"},
            {14'b0, dn_so, up_so}, {14'b0, it.dn_so, it.up_so});
      end
    end
  end

  initial begin
    #(P * 200000);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    chain = DEFS;
    #1 rst = 1'b1;
    #1;
    // R4: defaults appear at once, before any clock edge
    chk("R4 reset word", {dn_cfg, up_cfg}, DEFS);
    chk("R4 reset serial", {14'b0, dn_so, up_so}, {14'b0, DEFS[15], DEFS[7]});

    // R5: clocking with data while reset is held changes nothing
    tick(1'b1, "R5 reset held");
    tick(1'b1, "R5 reset held");
    tick(1'b0, "R5 reset held");
    release_reset();

    // R6: first edges after release push defaults downstream
    for (int i = 0; i < 4; i++) tick(1'b0, "R6 defaults move on");

    // R1 / R3: whole words through both chips
    shift_word(16'hC35A, "R1 shift");
    check_slices(16'hC35A);
    shift_word(16'h0FF0, "R1 shift");
    check_slices(16'h0FF0);
    shift_word(16'hFFFF, "R1 shift");
    check_slices(16'hFFFF);
    shift_word(16'h8001, "R1 shift");
    check_slices(16'h8001);

    // R4 / R5: reset lands mid-stream between a falling and a rising edge
    for (int i = 0; i < 5; i++) tick(i[0], "R1 partial");
    rst = 1'b1;
    #1;
    chk("R4 mid-shift reset word", {dn_cfg, up_cfg}, DEFS);
    chk("R4 mid-shift reset serial", {14'b0, dn_so, up_so}, {14'b0, DEFS[15], DEFS[7]});
    sbq[$].cfg   = DEFS;
    sbq[$].up_so = DEFS[7];
    sbq[$].dn_so = DEFS[15];
    chain = DEFS;
    tick(1'b1, "R5 reset wins over shift");
    tick(1'b0, "R5 reset wins over shift");
    release_reset();

    // R6 / R3: load again from the default contents
    shift_word(16'h5AA5, "R6 reload");
    check_slices(16'h5AA5);

    @(posedge clk);
    #(P/2);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule